// File: doc/BRIEF.md
# Half-Sine Table PWM Modulator for a Bridge Inverter

This block drives the two fast-switching legs of a full-bridge inverter with unipolar sinusoidal PWM. A free-running carrier counter spans a fixed number of clocks per carrier period. At each carrier boundary the next duty value is taken from a built-in half-sine table and held for the whole period. The output is high while the counter is below that duty value, so the pulse is edge-aligned and starts at the top of each period.

The table draws one half-wave. Every entry is computed when the design is elaborated from a quarter-wave sine, and the falling half mirrors the rising half. Only one leg carries the modulation at a time. When the last step of a half-wave has finished, the step index returns to zero, the leg-select flag flips, and the next half-wave is steered to the other leg. The idle leg is held low. No dead-time is added: the duty is close to zero at both ends of every half-wave, and that near-zero stretch separates the two legs at the polarity change. With the default settings (1000-clock carrier, 240 steps) and a 24 MHz clock, one half-wave lasts about 10 ms.

Top module: `sine_pwm_mod`

## Requirements
- R1: While reset is asserted and afterwards until the first enabled clock, the step index is 0, the leg-select flag is 0, and both PWM outputs are low.
- R2: A carrier period lasts CARRIER enabled clocks. The step index rises by one at each carrier boundary, so step s occupies CARRIER consecutive enabled clocks.
- R3: The duty of step s is floor(AMP·sin((π/2)·k/Q)), with Q = STEPS/2, k = s+1 for s < Q and k = STEPS−s otherwise. With the defaults, the first four steps give 13, 26, 39 and 52, steps 119 and 120 give 1000, and step 239 gives 13.
- R4: Within a carrier period the active output is high on exactly the first duty clocks, while the counter is below the duty value, and low for the rest.
- R5: A duty value takes effect only at a carrier boundary. The high time in each period equals the table value of that single step.
- R6: After step STEPS−1 has run its full period, the step index returns to 0 and the leg-select flag inverts in the same clock. The flag changes at no other time.
- R7: When leg-select is 0, the modulation appears on pwm_a_o and pwm_b_o stays low. When leg-select is 1, the roles are swapped.
- R8: pwm_a_o and pwm_b_o are never high at the same time. No extra delay is added between them.
- R9: While en_i is low, both outputs are low and the counter, step index, leg-select flag and duty are all held. When en_i returns high, the sequence resumes from the held position.
- R10: The first enabled clock after reset loads the duty of step 0 and does not advance the counter. Step 0 then runs for a full period, starting with the next enabled clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low pauses the modulator and forces both outputs low |
| pwm_a_o | output | 1 | Modulated drive for the first bridge leg (leg-select 0) |
| pwm_b_o | output | 1 | Modulated drive for the second bridge leg (leg-select 1) |
| step_o | output | IDX_W | Index of the half-sine step now playing |
| leg_sel_o | output | 1 | Leg carrying the modulation in this half-wave |

## Verification
The outputs are decoded from registers, and en_i gates them directly. A new step index and its duty therefore appear in the clock that follows the boundary edge, and a change on en_i shows up on the outputs in the same cycle. The bench drives every input just after a falling edge and updates its behavioural model just after the rising edge. It then compares outputs at the next falling edge, so every expected value is due in the sampled cycle. Each duty is measured by counting the high samples over exactly CARRIER enabled clocks, beginning with the clock after the loading edge. Both the literal table values and the mirror symmetry are checked at the level of single periods.

// File: rtl/sine_pwm_pkg.sv
package sine_pwm_pkg;

    localparam int DEF_CARRIER = 1000;
    localparam int DEF_STEPS   = 240;

    // Duty of one half-wave step: quarter-wave sine with a mirrored fall.
    function automatic int half_sine_duty(input int step, input int steps, input int amp);
        int  quarter;
        int  k;
        real ang;
        quarter = steps / 2;
        k       = (step < quarter) ? step + 1 : steps - step;
        ang     = (3.14159265358979323846 / 2.0) * real'(k) / real'(quarter);
        return $rtoi(real'(amp) * $sin(ang) + 1.0e-6);
    endfunction

endpackage

// File: rtl/sine_pwm_rom.sv
module sine_pwm_rom #(
    parameter int STEPS  = sine_pwm_pkg::DEF_STEPS,
    parameter int AMP    = sine_pwm_pkg::DEF_CARRIER,
    parameter int IDX_W  = $clog2(STEPS),
    parameter int DUTY_W = $clog2(AMP + 1)
) (
    input  logic [IDX_W-1:0]  addr_i,
    output logic [DUTY_W-1:0] duty_o
);

    logic [DUTY_W-1:0] table_w [STEPS];

    for (genvar g = 0; g < STEPS; g++) begin : g_entry
        localparam int VAL = sine_pwm_pkg::half_sine_duty(g, STEPS, AMP);
        assign table_w[g] = DUTY_W'(VAL);
    end

    always_comb begin
        duty_o = '0;
        if (int'(addr_i) < STEPS) begin
            duty_o = table_w[addr_i];
        end
    end

endmodule

// File: rtl/sine_pwm_steer.sv
module sine_pwm_steer #(
    parameter int CNT_W  = 10,
    parameter int DUTY_W = 10
) (
    input  logic              en_i,
    input  logic              sel_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [1:0]        leg_o
);

    localparam int CW = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;

    logic hit;
    assign hit = CW'(cnt_i) < CW'(duty_i);

    for (genvar l = 0; l < 2; l++) begin : g_leg
        assign leg_o[l] = en_i && (sel_i == 1'(l)) && hit;
    end

endmodule

// File: rtl/sine_pwm_mod.sv
module sine_pwm_mod #(
    parameter int CARRIER = sine_pwm_pkg::DEF_CARRIER,
    parameter int AMP     = CARRIER,
    parameter int STEPS   = sine_pwm_pkg::DEF_STEPS,
    parameter int IDX_W   = $clog2(STEPS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o,
    output logic [IDX_W-1:0] step_o,
    output logic             leg_sel_o
);

    localparam int CNT_W  = $clog2(CARRIER);
    localparam int DUTY_W = $clog2(AMP + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic              sel;
        logic [DUTY_W-1:0] duty;
        logic              live;
    } state_t;

    state_t            st_q, st_d;
    logic [IDX_W-1:0]  next_idx;
    logic              last_clk;
    logic              last_step;
    logic [IDX_W-1:0]  rom_addr;
    logic [DUTY_W-1:0] rom_duty;
    logic [1:0]        legs;

    assign last_clk  = (st_q.cnt == CNT_W'(CARRIER - 1));
    assign last_step = (st_q.idx == IDX_W'(STEPS - 1));
    assign next_idx  = last_step ? '0 : st_q.idx + 1'b1;
    assign rom_addr  = st_q.live ? next_idx : '0;

    sine_pwm_rom #(
        .STEPS (STEPS),
        .AMP   (AMP),
        .IDX_W (IDX_W),
        .DUTY_W(DUTY_W)
    ) u_rom (
        .addr_i(rom_addr),
        .duty_o(rom_duty)
    );

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            if (!st_q.live) begin
                st_d.live = 1'b1;
                st_d.duty = rom_duty;
            end else if (last_clk) begin
                st_d.cnt  = '0;
                st_d.idx  = next_idx;
                st_d.duty = rom_duty;
                if (last_step) begin
                    st_d.sel = ~st_q.sel;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sine_pwm_steer #(
        .CNT_W (CNT_W),
        .DUTY_W(DUTY_W)
    ) u_steer (
        .en_i  (en_i),
        .sel_i (st_q.sel),
        .cnt_i (st_q.cnt),
        .duty_i(st_q.duty),
        .leg_o (legs)
    );

    assign pwm_a_o   = legs[0];
    assign pwm_b_o   = legs[1];
    assign step_o    = st_q.idx;
    assign leg_sel_o = st_q.sel;

endmodule

// File: rtl/sine_pwm_chk.sv
module sine_pwm_chk #(
    parameter int STEPS = 240,
    parameter int IDX_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             pwm_a_o,
    input logic             pwm_b_o,
    input logic [IDX_W-1:0] step_o,
    input logic             leg_sel_o
);

    a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pwm_a_o && pwm_b_o));

    a_r7_idle_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
        leg_sel_o |-> !pwm_a_o);

    a_r7_idle_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !leg_sel_o |-> !pwm_b_o);

    a_r9_pause_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> (!pwm_a_o && !pwm_b_o));

    a_r9_pause_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_i) |-> ($stable(step_o) && $stable(leg_sel_o)));

    a_r2_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(step_o) < STEPS);

    a_r2_step_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_o != $past(step_o)) |-> (step_o == $past(step_o) + 1'b1 || step_o == '0));

    a_r6_flip_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (leg_sel_o != $past(leg_sel_o)) |->
            (step_o == '0 && $past(step_o) == IDX_W'(STEPS - 1)));

    a_r6_wrap_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_o == '0 && $past(step_o) == IDX_W'(STEPS - 1)) |->
            (leg_sel_o != $past(leg_sel_o)));

endmodule

bind sine_pwm_mod sine_pwm_chk #(
    .STEPS(STEPS),
    .IDX_W(IDX_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .pwm_a_o  (pwm_a_o),
    .pwm_b_o  (pwm_b_o),
    .step_o   (step_o),
    .leg_sel_o(leg_sel_o)
);

// File: tb/test_sine_pwm_mod.sv
module test_sine_pwm_mod;

    localparam int CLK_PERIOD = 10;
    localparam int S_CAR      = 100;
    localparam int S_STEPS    = 240;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_b = 1'b0;
    logic en_s = 1'b0;

    logic       a_b, b_b, sel_b;
    logic [7:0] idx_b;
    logic       a_s, b_s, sel_s;
    logic [7:0] idx_s;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sine_pwm_mod i_sine_pwm_mod (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en_b),
        .pwm_a_o(a_b), .pwm_b_o(b_b), .step_o(idx_b), .leg_sel_o(sel_b)
    );

    sine_pwm_mod #(.CARRIER(S_CAR), .AMP(S_CAR), .STEPS(S_STEPS)) i_small (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en_s),
        .pwm_a_o(a_s), .pwm_b_o(b_s), .step_o(idx_s), .leg_sel_o(sel_s)
    );

    // behavioural model of the small instance
    int m_live = 0, m_cnt = 0, m_idx = 0, m_sel = 0, m_duty = 0;

    function automatic int ref_duty(input int s, input int steps, input int amp);
        int  q;
        int  k;
        q = steps / 2;
        if (s < q) k = s + 1;
        else       k = steps - s;
        return $rtoi(real'(amp) * $sin(3.14159265358979323846 / 2.0 * real'(k) / real'(q)) + 1.0e-6);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one clock: drive enables, model update after the edge, compare at negedge
    task automatic tick(input bit es, input bit eb);
        int ea, eb2;
        en_s = es;
        en_b = eb;
        @(posedge clk);
        #1;
        if (es) begin
            if (m_live == 0) begin
                m_live = 1;
                m_duty = ref_duty(0, S_STEPS, S_CAR);
            end else if (m_cnt == S_CAR - 1) begin
                m_cnt = 0;
                m_idx++;
                if (m_idx == S_STEPS) begin
                    m_idx = 0;
                    m_sel = 1 - m_sel;
                end
                m_duty = ref_duty(m_idx, S_STEPS, S_CAR);
            end else begin
                m_cnt++;
            end
        end
        @(negedge clk);
        ea  = (es && m_sel == 0 && m_cnt < m_duty) ? 1 : 0;
        eb2 = (es && m_sel == 1 && m_cnt < m_duty) ? 1 : 0;
        chk(int'(a_s) == ea,  "R4", "small pwm_a", int'(a_s), ea);
        chk(int'(b_s) == eb2, "R7", "small pwm_b", int'(b_s), eb2);
        chk(int'(idx_s) == m_idx, "R2", "small step", int'(idx_s), m_idx);
        chk(int'(sel_s) == m_sel, "R6", "small leg_sel", int'(sel_s), m_sel);
        chk(!(a_s && b_s), "R8", "small both legs high", int'(a_s) + int'(b_s), 1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int lit[4];
        int hi;
        int flips;
        int prev_sel, prev_idx;
        lit[0] = 13; lit[1] = 26; lit[2] = 39; lit[3] = 52;

        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(idx_b == 0 && sel_b == 0, "R1", "step/leg in reset", int'(idx_b) + int'(sel_b), 0);
        chk(!a_b && !b_b, "R1", "outputs in reset", int'(a_b) + int'(b_b), 0);
        rst_n = 1'b1;
        tick(0, 0);
        chk(idx_b == 0 && sel_b == 0 && !a_b && !b_b, "R1", "idle after reset",
            int'(idx_b) + int'(sel_b) + int'(a_b), 0);

        // R3 R5 R10: default instance, first four steps, high count per period
        for (int p = 0; p < 4; p++) begin
            hi = 0;
            for (int c = 0; c < 1000; c++) begin
                tick(0, 1);
                if (c == 0) chk(int'(idx_b) == p, "R10", "step at period start", int'(idx_b), p);
                chk(!b_b, "R7", "default idle leg", int'(b_b), 0);
                if (a_b) hi++;
                if (c > 0 && c < 1000 && !a_b && c < lit[p])
                    chk(0, "R4", "pulse not leading", c, lit[p]);
            end
            chk(hi == lit[p], "R3", "default duty of step", hi, lit[p]);
            chk(hi == ref_duty(p, 240, 1000), "R5", "single duty per period", hi,
                ref_duty(p, 240, 1000));
        end
        // R3: peak and end values of the default table
        chk(ref_duty(119, 240, 1000) == 1000 && ref_duty(120, 240, 1000) == 1000,
            "R3", "model peak", ref_duty(119, 240, 1000), 1000);
        chk(ref_duty(239, 240, 1000) == 13, "R3", "model last", ref_duty(239, 240, 1000), 13);

        // R9: pause the default instance
        for (int c = 0; c < 20; c++) begin
            tick(0, 0);
            chk(!a_b && !b_b, "R9", "outputs while paused", int'(a_b) + int'(b_b), 0);
            chk(idx_b == 3 && sel_b == 0, "R9", "held step", int'(idx_b), 3);
        end

        // R2 R4 R6 R7 R8: small instance against the model across two wraps
        flips = 0;
        prev_sel = int'(sel_s);
        prev_idx = int'(idx_s);
        for (int c = 0; c < 30000; c++) begin
            tick(1, 0);
            if (int'(sel_s) != prev_sel) begin
                flips++;
                chk(idx_s == 0 && prev_idx == S_STEPS - 1, "R6", "flip at wrap",
                    int'(idx_s), 0);
            end
            prev_sel = int'(sel_s);
            prev_idx = int'(idx_s);
        end
        // R9: pause mid half-wave, then resume
        for (int c = 0; c < 300; c++) begin
            tick(0, 0);
            chk(!a_s && !b_s, "R9", "small outputs while paused", int'(a_s) + int'(b_s), 0);
        end
        for (int c = 0; c < 22000; c++) begin
            tick(1, 0);
            if (int'(sel_s) != prev_sel) begin
                flips++;
                chk(idx_s == 0 && prev_idx == S_STEPS - 1, "R6", "flip at wrap",
                    int'(idx_s), 0);
            end
            prev_sel = int'(sel_s);
            prev_idx = int'(idx_s);
        end
        chk(flips == 2, "R6", "number of half-wave changes", flips, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule